// File: doc/BRIEF.md
# Receive Error-Bit Policy Unit

This unit sits behind the bit-level receiver of a consumer-electronics control bus. The receiver measures each incoming bit and raises one-cycle pulses when it sees a rising edge at the wrong time, a bit period that is too short, or a bit period that is too long. This unit turns those pulses into decisions: whether the current reception is abandoned, and whether the node drives an error bit onto the shared line to tell the sender that the frame failed.

The decision depends on static configuration: a stop-on-rising-error enable, per-error generate enables for rising and long-period errors, and a broadcast quiet option. It also depends on the class of the current message (broadcast or directed) and on the listen mode. For broadcast frames the generate enables act in reverse, and the quiet option overrides them all. Each accepted error also latches a sticky flag that is cleared by writing a one. Once a reception is abandoned, further errors in that frame are dropped until the next message start. The unit also selects the acceptance-window limits for the receiver from a tolerance option.

Top module: `rx_errbit_policy`

## Requirements
- R1: After reset, abortRx and errBitReq are low, errFlags is 0, and nothing changes until an error pulse arrives.
- R2: A rising error aborts reception (abortRx pulses high in the cycle after the error) only when cfgStopOnRise is 1. Short-period and long-period errors always abort.
- R3: In a directed message (isBroadcast=0), a rising error requests an error bit only when cfgRiseGen and cfgStopOnRise are both 1.
- R4: In a directed message, a long-period error requests an error bit exactly when cfgLongGen is 1.
- R5: In a broadcast message with cfgBcastNoErr=0, a rising error requests an error bit when cfgStopOnRise=1 and cfgRiseGen=0. A long-period error requests one when cfgLongGen=0.
- R6: In a broadcast message with cfgBcastNoErr=1, no error of any kind requests an error bit.
- R7: A short-period error requests an error bit, except in a broadcast message while fullListen=1, or as stated in R6.
- R8: errFlags bit 0 holds rising errors, bit 1 short-period errors and bit 2 long-period errors. A bit sets one cycle after an accepted error and stays set. A 1 on the matching clrFlags bit clears it, and a set in the same cycle takes priority over the clear.
- R9: After an abort, error pulses set no flag, cause no abort and request no error bit until msgStart. An error in the same cycle as msgStart belongs to the new message.
- R10: errBitReq pulses only together with abortRx, so it pulses at most once per message.
- R11: winLow/winHigh equal the standard limits when cfgTolExt=0 and the extended limits when cfgTolExt=1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msgStart | input | 1 | Pulse marking the start of a new received message |
| errRise | input | 1 | Rising-edge timing error pulse |
| errShort | input | 1 | Short bit period error pulse |
| errLong | input | 1 | Long bit period error pulse |
| isBroadcast | input | 1 | Current message is broadcast |
| fullListen | input | 1 | Full listening mode active |
| cfgStopOnRise | input | 1 | Rising error aborts reception |
| cfgRiseGen | input | 1 | Rising-error generate enable |
| cfgLongGen | input | 1 | Long-period generate enable |
| cfgBcastNoErr | input | 1 | Suppress all error bits on broadcast |
| cfgTolExt | input | 1 | Select extended acceptance windows |
| clrFlags | input | 3 | Write-one-to-clear for errFlags |
| abortRx | output | 1 | One-cycle reception abort pulse |
| errBitReq | output | 1 | One-cycle error-bit request to the line driver |
| errFlags | output | 3 | Sticky error flags |
| winLow | output | CNT_W | Lower acceptance limit for the receiver |
| winHigh | output | CNT_W | Upper acceptance limit for the receiver |

## Verification
Some properties are checked by assertions on every cycle: an error-bit request always comes with an abort, an abort is never followed by another before a message start, the broadcast quiet option never lets an error bit through, and a flag only rises after its own error pulse. The full policy table needs the bench's scenarios. This covers the reversal of the enables for broadcast frames, the listen-mode exemption for short errors, the set-over-clear priority and the dropping of errors after an abort. The bench compares these with a reference model under random and directed stimulus.

// File: rtl/errpol_pkg.sv
package errpol_pkg;
  localparam int NUM_ERR = 3;
  localparam int FLG_RISE = 0;
  localparam int FLG_SHORT = 1;
  localparam int FLG_LONG = 2;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [NUM_ERR-1:0] setFlag;
    logic doAbort;
    logic doErrBit;
  } strobe_t;
endpackage

// File: rtl/errpol_ctrl.sv
module errpol_ctrl
  import errpol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic msgStart,
  input  logic [NUM_ERR-1:0] errIn,
  input  logic isBroadcast,
  input  logic fullListen,
  input  logic cfgStopOnRise,
  input  logic cfgRiseGen,
  input  logic cfgLongGen,
  input  logic cfgBcastNoErr,
  output strobe_t stb
);
  logic aborted;
  logic live;
  logic riseEb, shortEb, longEb;
  logic quiet;

  // an error in the message-start cycle belongs to the new message
  assign live = !(aborted && !msgStart);
  assign quiet = isBroadcast && cfgBcastNoErr;

  always_comb begin
    // rising error: needs stop; the generate enable is reversed for broadcast
    riseEb = cfgStopOnRise && (isBroadcast ? !cfgRiseGen : cfgRiseGen);
    longEb = isBroadcast ? !cfgLongGen : cfgLongGen;
    shortEb = !(isBroadcast && fullListen);
    stb = '0;
    if (live) begin
      stb.setFlag = errIn;
      stb.doAbort = (errIn[FLG_RISE] && cfgStopOnRise) || errIn[FLG_SHORT] || errIn[FLG_LONG];
      stb.doErrBit = !quiet && ((errIn[FLG_RISE] && riseEb) ||
                                (errIn[FLG_SHORT] && shortEb) ||
                                (errIn[FLG_LONG] && longEb));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aborted <= 1'b0;
    else if (!live) aborted <= 1'b1;
    else aborted <= stb.doAbort;
  end
endmodule

// File: rtl/errpol_datapath.sv
module errpol_datapath
  import errpol_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int STD_LO = 20,
  parameter int STD_HI = 30,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  strobe_t stb,
  input  logic [NUM_ERR-1:0] clrFlags,
  input  logic cfgTolExt,
  output logic abortRx,
  output logic errBitReq,
  output logic [NUM_ERR-1:0] errFlags,
  output logic [CNT_W-1:0] winLow,
  output logic [CNT_W-1:0] winHigh
);
  localparam logic [CNT_W-1:0] STD_LO_V = CNT_W'(STD_LO);
  localparam logic [CNT_W-1:0] STD_HI_V = CNT_W'(STD_HI);
  localparam logic [CNT_W-1:0] EXT_LO_V = CNT_W'(EXT_LO);
  localparam logic [CNT_W-1:0] EXT_HI_V = CNT_W'(EXT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abortRx <= 1'b0;
      errBitReq <= 1'b0;
    end else begin
      abortRx <= stb.doAbort;
      errBitReq <= stb.doErrBit;
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) errFlags[i] <= 1'b0;
      else if (stb.setFlag[i]) errFlags[i] <= 1'b1;
      else if (clrFlags[i]) errFlags[i] <= 1'b0;
    end

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (errFlags[i] && !$past(errFlags[i])) |-> $past(stb.setFlag[i])); // R8
  end

  assign winLow = cfgTolExt ? EXT_LO_V : STD_LO_V;
  assign winHigh = cfgTolExt ? EXT_HI_V : STD_HI_V;
endmodule

// File: rtl/rx_errbit_policy.sv
module rx_errbit_policy
  import errpol_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int STD_LO = 20,
  parameter int STD_HI = 30,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msgStart,
  input  logic errRise,
  input  logic errShort,
  input  logic errLong,
  input  logic isBroadcast,
  input  logic fullListen,
  input  logic cfgStopOnRise,
  input  logic cfgRiseGen,
  input  logic cfgLongGen,
  input  logic cfgBcastNoErr,
  input  logic cfgTolExt,
  input  logic [2:0] clrFlags,
  output logic abortRx,
  output logic errBitReq,
  output logic [2:0] errFlags,
  output logic [CNT_W-1:0] winLow,
  output logic [CNT_W-1:0] winHigh
);
  logic [NUM_ERR-1:0] errIn;
  strobe_t stb;

  always_comb begin
    errIn = '0;
    errIn[FLG_RISE] = errRise;
    errIn[FLG_SHORT] = errShort;
    errIn[FLG_LONG] = errLong;
  end

  errpol_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .msgStart(msgStart), .errIn(errIn),
    .isBroadcast(isBroadcast), .fullListen(fullListen),
    .cfgStopOnRise(cfgStopOnRise), .cfgRiseGen(cfgRiseGen),
    .cfgLongGen(cfgLongGen), .cfgBcastNoErr(cfgBcastNoErr), .stb(stb)
  );

  errpol_datapath #(
    .CNT_W(CNT_W), .STD_LO(STD_LO), .STD_HI(STD_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .clrFlags(clrFlags), .cfgTolExt(cfgTolExt),
    .abortRx(abortRx), .errBitReq(errBitReq), .errFlags(errFlags),
    .winLow(winLow), .winHigh(winHigh)
  );

  AST_ERRBIT_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    errBitReq |-> abortRx); // R10

  AST_ONE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (abortRx && !msgStart) |=> !abortRx); // R9

  AST_BCAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    errBitReq |-> !$past(isBroadcast && cfgBcastNoErr)); // R6

  AST_NO_ABORT_UNSTOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    abortRx |-> $past(errShort || errLong || (errRise && cfgStopOnRise))); // R2
endmodule

// File: tb/rx_errbit_policy_tb.sv
`timescale 1ns/1ps
module rx_errbit_policy_tb;
  localparam int CNT_W = 8;
  localparam int STD_LO = 20, STD_HI = 30, EXT_LO = 16, EXT_HI = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msgStart = 0, errRise = 0, errShort = 0, errLong = 0;
  logic isBroadcast = 0, fullListen = 0, cfgStopOnRise = 0, cfgRiseGen = 0;
  logic cfgLongGen = 0, cfgBcastNoErr = 0, cfgTolExt = 0;
  logic [2:0] clrFlags = 3'b000;
  logic abortRx, errBitReq;
  logic [2:0] errFlags;
  logic [CNT_W-1:0] winLow, winHigh;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit refAborted = 0;
  bit [2:0] refFlags = 3'b000;

  always #2.5 clk = ~clk;

  rx_errbit_policy #(.CNT_W(CNT_W), .STD_LO(STD_LO), .STD_HI(STD_HI),
                     .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .msgStart(msgStart), .errRise(errRise),
    .errShort(errShort), .errLong(errLong), .isBroadcast(isBroadcast),
    .fullListen(fullListen), .cfgStopOnRise(cfgStopOnRise), .cfgRiseGen(cfgRiseGen),
    .cfgLongGen(cfgLongGen), .cfgBcastNoErr(cfgBcastNoErr), .cfgTolExt(cfgTolExt),
    .clrFlags(clrFlags), .abortRx(abortRx), .errBitReq(errBitReq),
    .errFlags(errFlags), .winLow(winLow), .winHigh(winHigh)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected error-bit request from the policy requirements R3..R7
  function automatic bit expErrBit(bit r, bit s, bit l, bit bc, bit fl,
                                   bit st, bit rg, bit lg, bit bn);
    bit rEb, lEb, sEb;
    if (bc && bn) return 0;                      // R6
    rEb = st && (bc ? !rg : rg);                 // R3, R5
    lEb = bc ? !lg : lg;                         // R4, R5
    sEb = !(bc && fl);                           // R7
    return (r && rEb) || (s && sEb) || (l && lEb);
  endfunction

  task automatic step(input bit ms, r, s, l, bc, fl, st, rg, lg, bn, te,
                      input bit [2:0] clr);
    bit live, expAb, expEb;
    bit [2:0] setv;
    string ebTag;
    msgStart = ms; errRise = r; errShort = s; errLong = l;
    isBroadcast = bc; fullListen = fl; cfgStopOnRise = st; cfgRiseGen = rg;
    cfgLongGen = lg; cfgBcastNoErr = bn; cfgTolExt = te; clrFlags = clr;
    live = !(refAborted && !ms);
    expAb = live && ((r && st) || s || l);
    expEb = live && expErrBit(r, s, l, bc, fl, st, rg, lg, bn);
    setv = live ? {l, s, r} : 3'b000;
    refFlags = setv | (refFlags & ~clr);
    refAborted = live ? expAb : 1'b1;
    #1;
    check("R11 winLow", int'(winLow), te ? EXT_LO : STD_LO);
    check("R11 winHigh", int'(winHigh), te ? EXT_HI : STD_HI);
    @(negedge clk);
    if (!live) ebTag = "R9 errBitReq";
    else if (bc && bn) ebTag = "R6 errBitReq";
    else if (s && bc && fl) ebTag = "R7 errBitReq";
    else if (bc) ebTag = "R5 errBitReq";
    else if (l) ebTag = "R4 errBitReq";
    else ebTag = "R3 errBitReq";
    check(live ? "R2 abortRx" : "R9 abortRx", int'(abortRx), int'(expAb));
    check(ebTag, int'(errBitReq), int'(expEb));
    check(live ? "R8 errFlags" : "R9 errFlags", int'(errFlags), int'(refFlags));
    if (errBitReq && !abortRx) check("R10 errBitReq needs abortRx", 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 abortRx", int'(abortRx), 0);
    check("R1 errBitReq", int'(errBitReq), 0);
    check("R1 errFlags", int'(errFlags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0,0,0,0, 0,0,0,0,0,0,0, 3'b000);  // R1 idle after reset

    // directed corner cases          ms r s l bc fl st rg lg bn te clr
    step(1,1,0,0, 0,0,1,1,0,0,0, 3'b000);  // R2 R3 rise, stop+gen, directed
    step(1,1,0,0, 0,0,0,1,0,0,0, 3'b000);  // R2 rise without stop: no abort
    step(0,1,0,0, 0,0,1,0,0,0,1, 3'b000);  // R3 stop but no gen: abort only
    step(1,1,0,0, 1,0,1,0,0,0,0, 3'b111);  // R5 broadcast reversed rise
    step(1,0,0,1, 1,0,0,0,1,0,0, 3'b000);  // R5 broadcast long with gen set: none
    step(1,0,0,1, 1,0,0,0,0,1,0, 3'b000);  // R6 quiet broadcast
    step(1,0,1,0, 1,1,0,0,0,0,1, 3'b000);  // R7 broadcast short full listen
    step(1,0,1,0, 0,1,0,0,0,0,0, 3'b000);  // R7 directed short
    step(1,0,0,1, 0,0,0,0,0,0,0, 3'b111);  // R4 directed long, gen clear
    step(0,0,0,1, 0,0,0,0,1,0,0, 3'b000);  // R9 ignored after abort
    step(0,1,1,1, 0,0,1,1,1,0,0, 3'b000);  // R9 still ignored
    step(1,0,0,1, 0,0,0,0,1,0,0, 3'b100);  // R8 set beats clear, R4 gen set
    step(1,0,0,0, 0,0,0,0,0,0,0, 3'b111);  // R8 clear all

    // random stimulus with sparse errors
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 12) == 0,
           ($urandom % 12) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
           (($urandom % 5) == 0) ? 3'($urandom) : 3'b000);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule